// File: doc/BRIEF.md
# Load-Store Register Machine Core

This block is a compact multi-cycle processor core. It has eight 32-bit general-purpose registers and carries out one instruction at a time. Memory is reached only through loads and stores. Arithmetic takes its operands from registers and writes its result to a register. The core has no branches, no immediates, no interrupts and no pipeline: it fetches an instruction, executes it, and moves on to the next instruction in byte order until it reaches a halt.

The core talks to memory through a byte-wide synchronous port with a 24-bit byte address. A read request made in one cycle returns its data on `mem_rdata_i` in the next cycle. A write takes effect at the clock edge that ends the cycle in which `mem_we_o` is high. There are two instruction formats, and the first byte fetched (the opcode) decides how long the instruction is. The memory format is 5 bytes and names one register and one 24-bit address. The register format is 3 bytes and names a destination register and two source registers. Data words are big-endian in memory. `halted_o` reports that the core has stopped.

Top module: `lsc_core`

## Requirements
- R1: While `rst_ni` is low, the core resets: the program counter is 0, all eight registers hold zero, `halted_o` is low, no write is requested, and the memory request is a read of address 0.
- R2: Opcode 0x01 (load) uses the 5-byte format. Seen as a big-endian 40-bit word, the instruction holds the opcode in bits [39:32], a register code in [31:29], an address in [28:5] and zero pad in [4:0]. A load reads the bytes at address, address+1, address+2 and address+3, takes the first byte as the most significant, and writes the 32-bit word into the named register.
- R3: Opcode 0x02 (store) uses the same 5-byte format. It writes the named register to address..address+3, most significant byte first. Each store makes exactly four byte writes.
- R4: Opcodes 0x10 (add), 0x11 (subtract) and 0x12 (multiply) use the 3-byte format. Seen as a big-endian 24-bit word, the instruction holds the opcode in [23:16], the destination code in [15:13], source A in [12:10], source B in [9:7] and zero pad in [6:0]. The result is A+B, A-B, or the low 32 bits of A*B, all modulo 2^32.
- R5: Register code k (0 to 7) selects register R(k+1). All eight registers are independent storage.
- R6: When the destination of an arithmetic instruction is also one of its sources, the result is computed from the source values held before the instruction.
- R7: The program counter moves forward by 5 after a load or store and by 3 after an arithmetic instruction. The next opcode is fetched from the byte that directly follows the current instruction.
- R8: Opcode 0xFF (halt) is a single byte. It raises `halted_o`, which stays high until reset. While halted, the core makes no memory read or write.
- R9: Any opcode not listed above halts the core after its first byte is fetched. No further instruction executes.
- R10: Only store instructions drive memory writes. Fetches, loads and arithmetic instructions never write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 24 | Byte address of the current memory request |
| mem_rd_o | output | 1 | Read request; the data arrives on the next cycle |
| mem_we_o | output | 1 | Byte write request |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_rd_o` |
| halted_o | output | 1 | Core has stopped |

## Verification
The register file can be read and written in the same cycle. An arithmetic instruction reads its sources and writes its destination at one clock edge, so an instruction whose destination is also a source makes both happen to the same register together. The bench provokes this with add and multiply instructions that write back into their own source register. It then stores those registers and compares the stored words with sums and products computed in the bench from the values as they stood before the instruction. A sweep that rotates the register codes also puts every code into each role in turn.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_ADD   = 8'h10;
  localparam logic [7:0] OP_SUB   = 8'h11;
  localparam logic [7:0] OP_MUL   = 8'h12;
  localparam logic [7:0] OP_HALT  = 8'hFF;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_MUL
  } alu_op_e;

  typedef enum logic [2:0] {
    S_FREQ,
    S_FCAP,
    S_EXEC,
    S_LREQ,
    S_LCAP,
    S_LWB,
    S_STORE,
    S_HALT
  } state_e;

  function automatic logic is_mem_op(input logic [7:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic is_alu_op(input logic [7:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   ra_i,
  input  logic [IW-1:0]   rb_i,
  output logic [XLEN-1:0] rda_o,
  output logic [XLEN-1:0] rdb_o,
  input  logic            we_i,
  input  logic [IW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs[g] <= '0;
      else if (we_i && wa_i == IW'(g))   regs[g] <= wd_i;
    end
  end

  // combinational reads: sources seen before the write edge (old values)
  assign rda_o = regs[ra_i];
  assign rdb_o = regs[rb_i];

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs[$past(wa_i)] == $past(wd_i));

endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_MUL: res_o = a_i * b_i;
      default: res_o = a_i + b_i;
    endcase
  end

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  parameter int AW   = 24,
  localparam int IW      = $clog2(NREG),
  localparam int WB      = XLEN / 8,
  localparam int DW      = $clog2(WB),
  localparam int MEM_LEN = (8 + IW + AW + 7) / 8,
  localparam int REG_LEN = (8 + 3 * IW + 7) / 8,
  localparam int IB_W    = MEM_LEN * 8,
  localparam int RB_W    = REG_LEN * 8,
  localparam int BCW     = $clog2(MEM_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_rd_o,
  output logic            mem_we_o,
  output logic [7:0]      mem_wdata_o,
  input  logic [7:0]      mem_rdata_i,
  output logic            halted_o,
  output logic [IW-1:0]   rf_ra_o,
  output logic [IW-1:0]   rf_rb_o,
  input  logic [XLEN-1:0] rf_rda_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_wa_o,
  output logic [XLEN-1:0] rf_wd_o,
  output alu_op_e         alu_op_o,
  input  logic [XLEN-1:0] alu_res_i
);

  state_e          state_q;
  logic [AW-1:0]   pc_q;
  logic [BCW-1:0]  bcnt_q;
  logic [DW-1:0]   dcnt_q;
  logic [7:0]      op_q;
  logic [IB_W-1:0] ibuf_q;
  logic [XLEN-1:0] ld_q;

  // instruction fields, packed from the top of each format
  logic [IW-1:0]   m_reg, r_rd, r_sa, r_sb;
  logic [AW-1:0]   m_addr;
  assign m_reg  = ibuf_q[IB_W-9 -: IW];
  assign m_addr = ibuf_q[IB_W-9-IW -: AW];
  assign r_rd   = ibuf_q[RB_W-9 -: IW];
  assign r_sa   = ibuf_q[RB_W-9-IW -: IW];
  assign r_sb   = ibuf_q[RB_W-9-2*IW -: IW];

  // length decode: opcode comes from the port on the first byte
  logic [7:0]     cur_op;
  logic [BCW-1:0] need_len;
  assign cur_op = (bcnt_q == '0) ? mem_rdata_i : op_q;
  always_comb begin
    if (is_mem_op(cur_op))      need_len = BCW'(MEM_LEN);
    else if (is_alu_op(cur_op)) need_len = BCW'(REG_LEN);
    else                        need_len = '0;
  end

  logic [XLEN-1:0] st_word;
  assign st_word = rf_rda_i >> {DW'(WB - 1) - dcnt_q, 3'b000};

  always_comb begin
    unique case (op_q)
      OP_SUB:  alu_op_o = ALU_SUB;
      OP_MUL:  alu_op_o = ALU_MUL;
      default: alu_op_o = ALU_ADD;
    endcase
  end

  assign rf_ra_o  = (op_q == OP_STORE) ? m_reg : r_sa;
  assign rf_rb_o  = r_sb;
  assign halted_o = (state_q == S_HALT);

  always_comb begin
    mem_addr_o  = '0;
    mem_rd_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    rf_we_o     = 1'b0;
    rf_wa_o     = m_reg;
    rf_wd_o     = ld_q;
    unique case (state_q)
      S_FREQ: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = pc_q + AW'(bcnt_q);
      end
      S_EXEC: begin
        if (is_alu_op(op_q)) begin
          rf_we_o = 1'b1;
          rf_wa_o = r_rd;
          rf_wd_o = alu_res_i;
        end
      end
      S_LREQ: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = m_addr + AW'(dcnt_q);
      end
      S_LWB: rf_we_o = 1'b1;
      S_STORE: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = m_addr + AW'(dcnt_q);
        mem_wdata_o = st_word[7:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FREQ;
      pc_q    <= '0;
      bcnt_q  <= '0;
      dcnt_q  <= '0;
      op_q    <= '0;
      ibuf_q  <= '0;
      ld_q    <= '0;
    end else begin
      unique case (state_q)
        S_FREQ: state_q <= S_FCAP;
        S_FCAP: begin
          ibuf_q <= {ibuf_q[IB_W-9:0], mem_rdata_i};
          if (bcnt_q == '0) op_q <= mem_rdata_i;
          if (need_len == '0) begin
            state_q <= S_HALT;
          end else if (bcnt_q + BCW'(1) == need_len) begin
            bcnt_q  <= '0;
            state_q <= S_EXEC;
          end else begin
            bcnt_q  <= bcnt_q + BCW'(1);
            state_q <= S_FREQ;
          end
        end
        S_EXEC: begin
          dcnt_q <= '0;
          if (is_alu_op(op_q)) begin
            pc_q    <= pc_q + AW'(REG_LEN);
            state_q <= S_FREQ;
          end else if (op_q == OP_LOAD) begin
            state_q <= S_LREQ;
          end else begin
            state_q <= S_STORE;
          end
        end
        S_LREQ: state_q <= S_LCAP;
        S_LCAP: begin
          ld_q <= {ld_q[XLEN-9:0], mem_rdata_i};
          if (dcnt_q == DW'(WB - 1)) begin
            dcnt_q  <= '0;
            state_q <= S_LWB;
          end else begin
            dcnt_q  <= dcnt_q + DW'(1);
            state_q <= S_LREQ;
          end
        end
        S_LWB: begin
          pc_q    <= pc_q + AW'(MEM_LEN);
          state_q <= S_FREQ;
        end
        S_STORE: begin
          if (dcnt_q == DW'(WB - 1)) begin
            dcnt_q  <= '0;
            pc_q    <= pc_q + AW'(MEM_LEN);
            state_q <= S_FREQ;
          end else begin
            dcnt_q  <= dcnt_q + DW'(1);
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  a_r10_store_only_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (op_q == OP_STORE));

  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_rd_o && !mem_we_o));

  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  a_r7_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |->
      ((pc_q - $past(pc_q)) == AW'(REG_LEN) || (pc_q - $past(pc_q)) == AW'(MEM_LEN)));

  a_r9_undef_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FCAP && bcnt_q == '0 && !is_mem_op(mem_rdata_i) && !is_alu_op(mem_rdata_i))
      |=> halted_o);

endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  parameter int AW   = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          halted_o
);

  localparam int IW = $clog2(NREG);

  logic [IW-1:0]   ra, rb, wa;
  logic [XLEN-1:0] rda, rdb, wd, alu_res;
  logic            we;
  alu_op_e         alu_op;

  lsc_ctrl #(.NREG(NREG), .XLEN(XLEN), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .halted_o    (halted_o),
    .rf_ra_o     (ra),
    .rf_rb_o     (rb),
    .rf_rda_i    (rda),
    .rf_we_o     (we),
    .rf_wa_o     (wa),
    .rf_wd_o     (wd),
    .alu_op_o    (alu_op),
    .alu_res_i   (alu_res)
  );

  lsc_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (ra),
    .rb_i   (rb),
    .rda_o  (rda),
    .rdb_o  (rdb),
    .we_i   (we),
    .wa_i   (wa),
    .wd_i   (wd)
  );

  lsc_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (alu_op),
    .a_i   (rda),
    .b_i   (rdb),
    .res_o (alu_res)
  );

  a_r3_no_rd_with_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));

endmodule

// File: tb/tb_lsc_core.sv
`timescale 1ns/1ps
module tb_lsc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_we, halted;
  logic [7:0]  mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  lsc_core dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted)
  );

  logic [7:0] mem [1024];
  int total = 0;
  int bad = 0;
  int wr_cnt, halt_acc;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt   <= 0;
      halt_acc <= 0;
    end else begin
      if (mem_we) wr_cnt <= wr_cnt + 1;
      if (halted && (mem_rd || mem_we)) halt_acc <= halt_acc + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdw(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction

  task automatic put_b(input int a, input logic [7:0] v);
    mem[a] <= v;
  endtask

  task automatic put_w(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a+i] <= v[31-8*i -: 8];
  endtask

  task automatic put_m(input int a, input logic [7:0] op, input logic [2:0] r, input logic [23:0] ad);
    logic [39:0] w;
    w = {op, r, ad, 5'b0};
    for (int i = 0; i < 5; i++) mem[a+i] <= w[39-8*i -: 8];
  endtask

  task automatic put_r(input int a, input logic [7:0] op, input logic [2:0] d,
                       input logic [2:0] sa, input logic [2:0] sb);
    logic [23:0] w;
    w = {op, d, sa, sb, 7'b0};
    for (int i = 0; i < 3; i++) mem[a+i] <= w[23-8*i -: 8];
  endtask

  task automatic run(input string tag);
    int n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state seen at the port
    chk({tag, " R1 reset port"}, {5'b0, mem_rd, mem_we, halted, mem_addr}, {5'b0, 3'b100, 24'h0});
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (12) @(negedge clk);
    chk({tag, " R8 halted"}, {31'b0, halted}, 32'd1);
    chk({tag, " R8 quiet"}, 32'(halt_acc), 32'd0);
  endtask

  logic [31:0] lcg = 32'h1234_5678;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
    @(negedge clk);

    // main sweep: loads, three ALU ops, stores with rotating register codes
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      logic [2:0]  ra, rb, rs, rdf, rp;
      case (i)
        0: begin a = 32'h0;        b = 32'h0;        end
        1: begin a = 32'hFFFFFFFF; b = 32'h1;        end
        2: begin a = 32'h80000000; b = 32'h80000000; end
        3: begin a = 32'h7FFFFFFF; b = 32'hFFFFFFFF; end
        default: begin
          lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
          lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg;
        end
      endcase
      ra = 3'(i); rb = 3'(i + 3); rs = 3'(i + 5); rdf = 3'(i + 6); rp = 3'(i + 7);
      put_m(0,  8'h01, ra, 24'h200);
      put_m(5,  8'h01, rb, 24'h204);
      put_r(10, 8'h10, rs, ra, rb);
      put_r(13, 8'h11, rdf, ra, rb);
      put_r(16, 8'h12, rp, ra, rb);
      put_m(19, 8'h02, rs, 24'h300);
      put_m(24, 8'h02, rdf, 24'h304);
      put_m(29, 8'h02, rp, 24'h308);
      put_m(34, 8'h02, ra, 24'h30C);
      put_b(39, 8'hFF);
      put_w(12'h200, a);
      put_w(12'h204, b);
      for (int k = 0; k < 4; k++) put_w(12'h300 + 4*k, 32'h5A5A5A5A);
      run("sweep");
      chk("R4 add", rdw(12'h300), a + b);
      chk("R4 sub", rdw(12'h304), a - b);
      chk("R4 mul", rdw(12'h308), a * b);
      chk("R2 load roundtrip", rdw(12'h30C), a);
      chk("R3 write count", 32'(wr_cnt), 32'd16);
    end

    // R7: stride check via a longer chain of mixed lengths
    put_m(0, 8'h01, 3'd0, 24'h200);
    put_r(5, 8'h10, 3'd1, 3'd0, 3'd0);
    put_r(8, 8'h10, 3'd2, 3'd1, 3'd1);
    put_r(11, 8'h10, 3'd3, 3'd2, 3'd2);
    put_m(14, 8'h02, 3'd3, 24'h300);
    put_b(19, 8'hFF);
    put_w(12'h200, 32'h0000_0003);
    put_w(12'h300, 32'h0);
    run("stride");
    chk("R7 chained result", rdw(12'h300), 32'd24);

    // R5: eight independent registers
    for (int k = 0; k < 8; k++) begin
      put_m(5*k, 8'h01, 3'(k), 24'h200 + 24'(4*k));
      put_m(40 + 5*k, 8'h02, 3'(k), 24'h300 + 24'(4*(7-k)));
      put_w(12'h200 + 4*k, 32'h11111111 * (k + 1));
    end
    put_b(80, 8'hFF);
    run("regs");
    for (int k = 0; k < 8; k++)
      chk("R5 register code", rdw(12'h300 + 4*(7-k)), 32'h11111111 * (k + 1));

    // R6: destination equals a source
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a, b;
      logic [2:0]  c0, c2;
      lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg;
      if (i == 0) begin a = 32'hFFFFFFFF; b = 32'h2; end
      c0 = 3'(i); c2 = 3'(i + 2);
      put_m(0,  8'h01, c2, 24'h200);
      put_m(5,  8'h01, c0, 24'h204);
      put_r(10, 8'h10, c2, c2, c0);
      put_r(13, 8'h12, c0, c0, c0);
      put_m(16, 8'h02, c2, 24'h300);
      put_m(21, 8'h02, c0, 24'h304);
      put_b(26, 8'hFF);
      put_w(12'h200, b);
      put_w(12'h204, a);
      run("overlap");
      chk("R6 add into source", rdw(12'h300), b + a);
      chk("R6 mul into source", rdw(12'h304), a * a);
    end

    // R10: arithmetic-only program makes no writes
    put_m(0, 8'h01, 3'd0, 24'h200);
    put_m(5, 8'h01, 3'd1, 24'h204);
    put_r(10, 8'h10, 3'd2, 3'd0, 3'd1);
    put_r(13, 8'h11, 3'd3, 3'd2, 3'd1);
    put_r(16, 8'h12, 3'd4, 3'd3, 3'd0);
    put_b(19, 8'hFF);
    put_w(12'h200, 32'h0000_0300);
    put_w(12'h204, 32'h0000_0304);
    put_w(12'h300, 32'hC3C3C3C3);
    run("noalu_wr");
    chk("R10 write count", 32'(wr_cnt), 32'd0);
    chk("R10 memory untouched", rdw(12'h300), 32'hC3C3C3C3);

    // R9: undefined opcodes stop the core; R1: registers reset to zero
    for (int i = 0; i < 5; i++) begin
      logic [7:0] bad_op;
      case (i)
        0: bad_op = 8'h00;
        1: bad_op = 8'h03;
        2: bad_op = 8'h13;
        3: bad_op = 8'h80;
        default: bad_op = 8'hFE;
      endcase
      put_m(0, 8'h02, 3'd5, 24'h310);
      put_b(5, bad_op);
      put_m(6, 8'h02, 3'd6, 24'h314);
      put_b(11, 8'hFF);
      put_w(12'h310, 32'h11223344);
      put_w(12'h314, 32'h11223344);
      run("undef");
      chk("R1 register reset zero", rdw(12'h310), 32'h0);
      chk("R9 later store skipped", rdw(12'h314), 32'h11223344);
      chk("R9 write count", 32'(wr_cnt), 32'd4);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule